// File: doc/BRIEF.md
# Address Translation Front-End

This block turns a memory request's virtual address into a physical address, or into a fault code, one clock after the request is presented. Each request chooses one of three routes.

- A request flagged as physical keeps its address unchanged.
- A request in the direct-mapped kernel window (enabled by a control bit) is masked down to the implemented physical width.
- Any other request is checked for a well-formed virtual address and then looked up in a small fully associative page table. The table is keyed by virtual page number and address-space number.

Whatever route succeeds, the resulting address is finally checked against the implemented physical width. Address bits above that width give a machine-check result. This result is kept separate from the translation faults.

The table is filled through a one-cycle write port. The slot that each fill replaces is chosen round-robin. Six event counters record read and write activity on the lookup route:
- accesses
- hits
- malformed-address violations

Instruction fetches are counted as reads.

Top module: `xlat_frontend`

## Requirements
- R1: After reset, resp_valid_o is 0, all six counters read 0, and every table slot is empty, so any lookup misses.
- R2: A request with req_phys_i=1 returns resp_paddr_o equal to req_vaddr_i. It does no address-form check and no table lookup, and it leaves all counters unchanged.
- R3: When req_phys_i=0, ctl_spage_i[1]=1 and req_vaddr_i[42:41]=2'b10, a kernel request (req_kernel_i=1) returns req_vaddr_i with bits 63:40 cleared, with fault code 0 (none).
- R4: The same direct-mapped request in non-kernel mode returns fault code 3 (data access violation) for loads and stores, or code 1 (instruction access violation) for fetches. resp_paddr_o and resp_status_o are then 0.
- R5: On the lookup route, an address whose bits 63:42 are not all equal is malformed. It returns fault code 2 for data (code 1 for fetches). For data, resp_status_o has bit 2 (bad address) and bit 1 (access violation) set, and bit 0 set for stores. It increments the read or write violation counter.
- R6: On the lookup route, a valid slot whose page number equals req_vaddr_i[42:13] and whose space number equals ctx_asn_i hits. resp_paddr_o is then the stored frame number concatenated with req_vaddr_i[12:0].
- R7: A lookup that misses returns fault code 2 for data with resp_status_o bit 0 set only for stores, and fault code 1 with status 0 for fetches.
- R8: If a route succeeds with any of resp_paddr_o bits 63:40 set, the fault code is 4 (machine check). This applies on the physical route and on a table hit whose frame bit 27 is set; resp_paddr_o still shows the computed address.
- R9: Only lookup-route requests increment the access counters, and only hits increment the hit counters. A store (req_write_i=1, req_fetch_i=0) uses the write counters; anything else uses the read counters.
- R10: Fills write slots 0,1,...,15 in turn and then wrap around. A lookup in the same cycle as a fill sees the table as it was before that fill.
- R11: resp_valid_o equals req_valid_i of the previous cycle. While it is 0, resp_paddr_o, resp_fault_o and resp_status_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_vaddr_i | input | 64 | Virtual address |
| req_phys_i | input | 1 | Address is already physical |
| req_write_i | input | 1 | Store (ignored for fetches) |
| req_fetch_i | input | 1 | Instruction fetch |
| req_kernel_i | input | 1 | Requester is in kernel mode |
| ctx_asn_i | input | 8 | Current address-space number |
| ctl_spage_i | input | 2 | Direct-map control field; bit 1 enables the kernel window |
| fill_en_i | input | 1 | Write one table slot |
| fill_vpn_i | input | 30 | Page number of the new slot |
| fill_asn_i | input | 8 | Space number of the new slot |
| fill_pfn_i | input | 28 | Frame number of the new slot |
| resp_valid_o | output | 1 | Response present |
| resp_paddr_o | output | 64 | Physical address |
| resp_fault_o | output | 3 | 0 none, 1 instr violation, 2 data fault, 3 data violation, 4 machine check |
| resp_status_o | output | 3 | Data fault status: bit0 store, bit1 violation, bit2 bad address |
| cnt_rd_acc_o | output | 16 | Lookup-route read accesses |
| cnt_wr_acc_o | output | 16 | Lookup-route write accesses |
| cnt_rd_hit_o | output | 16 | Read hits |
| cnt_wr_hit_o | output | 16 | Write hits |
| cnt_rd_viol_o | output | 16 | Read malformed-address violations |
| cnt_wr_viol_o | output | 16 | Write malformed-address violations |

## Verification
A fill and a lookup of the same page can land in the same cycle. The lookup must then miss, and the next lookup of that page must hit. The bench provokes this both with a directed fill-and-lookup pair and with random fills that coincide with random lookups, and its own table model applies each fill only after predicting that cycle's response. The table-hit and machine-check outcomes also coincide on a single request: the hit counter must still advance while the fault reads machine check, which a frame number with its top bit set provokes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W      = 64;
    localparam int VA_IMPL_W = 43;
    localparam int PA_W      = 40;
    localparam int PG_W      = 13;
    localparam int ASN_W     = 8;
    localparam int PFN_W     = 28;
    localparam int VPN_W     = VA_IMPL_W - PG_W;

    localparam int ST_WR  = 0;
    localparam int ST_ACV = 1;
    localparam int ST_BAD = 2;

    localparam int CI_RD_ACC  = 0;
    localparam int CI_WR_ACC  = 1;
    localparam int CI_RD_HIT  = 2;
    localparam int CI_WR_HIT  = 3;
    localparam int CI_RD_VIOL = 4;
    localparam int CI_WR_VIOL = 5;
    localparam int NUM_CNT    = 6;

    localparam logic [VA_W-1:0] PA_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_IACV   = 3'd1,
        FLT_DFAULT = 3'd2,
        FLT_DACV   = 3'd3,
        FLT_MCHK   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        PATH_PHYS  = 2'd0,
        PATH_SUPER = 2'd1,
        PATH_TABLE = 2'd2
    } path_e;

    typedef struct packed {
        logic             valid;
        logic [ASN_W-1:0] asn;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } pte_t;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] paddr;
        fault_e          fault;
        logic [2:0]      status;
    } resp_t;

    // Address is well formed when every bit from the top of the
    // implemented range upward is a copy of the same value.
    function automatic logic va_well_formed(input logic [VA_W-1:0] va);
        return (&va[VA_W-1:VA_IMPL_W-1]) || ~(|va[VA_W-1:VA_IMPL_W-1]);
    endfunction

    function automatic logic va_in_kernel_window(input logic [VA_W-1:0] va);
        return va[VA_IMPL_W-1:VA_IMPL_W-2] == 2'b10;
    endfunction

endpackage

// File: rtl/xlat_classify.sv
module xlat_classify
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic             phys,
    input  logic             win_en,
    output path_e            path,
    output logic             well_formed,
    output logic [VPN_W-1:0] vpn,
    output logic [PG_W-1:0]  offset
);
    always_comb begin
        if (phys)
            path = PATH_PHYS;
        else if (win_en && va_in_kernel_window(vaddr))
            path = PATH_SUPER;
        else
            path = PATH_TABLE;
    end

    assign well_formed = va_well_formed(vaddr);
    assign vpn         = vaddr[VA_IMPL_W-1:PG_W];
    assign offset      = vaddr[PG_W-1:0];
endmodule

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [ASN_W-1:0] fill_asn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    pte_t             ents [ENTRIES];
    logic [IDX_W-1:0] rr_q;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ents[g].valid && (ents[g].vpn == lk_vpn) &&
                          (ents[g].asn == lk_asn);
    end

    always_comb begin
        lk_hit = |match;
        lk_pfn = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) lk_pfn = ents[i].pfn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
            rr_q <= '0;
        end else if (fill_en) begin
            ents[rr_q] <= '{valid: 1'b1, asn: fill_asn, vpn: fill_vpn, pfn: fill_pfn};
            rr_q       <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_counters.sv
module xlat_counters
    import xlat_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CNT-1:0]              inc,
    output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt
);
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= '0;
            else if (inc[g])
                cnt[g] <= cnt[g] + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_frontend.sv
module xlat_frontend
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid_i,
    input  logic [63:0]      req_vaddr_i,
    input  logic             req_phys_i,
    input  logic             req_write_i,
    input  logic             req_fetch_i,
    input  logic             req_kernel_i,
    input  logic [7:0]       ctx_asn_i,
    input  logic [1:0]       ctl_spage_i,
    input  logic             fill_en_i,
    input  logic [29:0]      fill_vpn_i,
    input  logic [7:0]       fill_asn_i,
    input  logic [27:0]      fill_pfn_i,
    output logic             resp_valid_o,
    output logic [63:0]      resp_paddr_o,
    output logic [2:0]       resp_fault_o,
    output logic [2:0]       resp_status_o,
    output logic [CNT_W-1:0] cnt_rd_acc_o,
    output logic [CNT_W-1:0] cnt_wr_acc_o,
    output logic [CNT_W-1:0] cnt_rd_hit_o,
    output logic [CNT_W-1:0] cnt_wr_hit_o,
    output logic [CNT_W-1:0] cnt_rd_viol_o,
    output logic [CNT_W-1:0] cnt_wr_viol_o
);
    path_e            path;
    logic             well_formed;
    logic [VPN_W-1:0] vpn;
    logic [PG_W-1:0]  offset;
    logic             tbl_hit;
    logic [PFN_W-1:0] tbl_pfn;
    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    resp_t            nxt, resp_q;
    logic             store;

    xlat_classify u_cls (
        .vaddr       (req_vaddr_i),
        .phys        (req_phys_i),
        .win_en      (ctl_spage_i[1]),
        .path        (path),
        .well_formed (well_formed),
        .vpn         (vpn),
        .offset      (offset)
    );

    xlat_table #(.ENTRIES(ENTRIES)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .lk_vpn   (vpn),
        .lk_asn   (ctx_asn_i),
        .lk_hit   (tbl_hit),
        .lk_pfn   (tbl_pfn),
        .fill_en  (fill_en_i),
        .fill_vpn (fill_vpn_i),
        .fill_asn (fill_asn_i),
        .fill_pfn (fill_pfn_i)
    );

    xlat_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (inc),
        .cnt (cnt)
    );

    assign store = req_write_i && !req_fetch_i;

    always_comb begin
        nxt = '0;
        inc = '0;
        nxt.fault = FLT_NONE;
        if (req_valid_i) begin
            nxt.valid = 1'b1;
            unique case (path)
                PATH_PHYS: nxt.paddr = req_vaddr_i;
                PATH_SUPER: begin
                    if (!req_kernel_i)
                        nxt.fault = req_fetch_i ? FLT_IACV : FLT_DACV;
                    else
                        nxt.paddr = req_vaddr_i & PA_MASK;
                end
                default: begin
                    inc[store ? CI_WR_ACC : CI_RD_ACC] = 1'b1;
                    if (!well_formed) begin
                        inc[store ? CI_WR_VIOL : CI_RD_VIOL] = 1'b1;
                        nxt.fault = req_fetch_i ? FLT_IACV : FLT_DFAULT;
                        if (!req_fetch_i) begin
                            nxt.status[ST_BAD] = 1'b1;
                            nxt.status[ST_ACV] = 1'b1;
                            nxt.status[ST_WR]  = store;
                        end
                    end else if (!tbl_hit) begin
                        nxt.fault = req_fetch_i ? FLT_IACV : FLT_DFAULT;
                        if (!req_fetch_i) nxt.status[ST_WR] = store;
                    end else begin
                        inc[store ? CI_WR_HIT : CI_RD_HIT] = 1'b1;
                        nxt.paddr = VA_W'({tbl_pfn, offset});
                    end
                end
            endcase
            if (nxt.fault == FLT_NONE && (|nxt.paddr[VA_W-1:PA_W]))
                nxt.fault = FLT_MCHK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q       <= '0;
            resp_q.fault <= FLT_NONE;
        end else begin
            resp_q <= nxt;
        end
    end

    assign resp_valid_o  = resp_q.valid;
    assign resp_paddr_o  = resp_q.paddr;
    assign resp_fault_o  = resp_q.fault;
    assign resp_status_o = resp_q.status;
    assign cnt_rd_acc_o  = cnt[CI_RD_ACC];
    assign cnt_wr_acc_o  = cnt[CI_WR_ACC];
    assign cnt_rd_hit_o  = cnt[CI_RD_HIT];
    assign cnt_wr_hit_o  = cnt[CI_WR_HIT];
    assign cnt_rd_viol_o = cnt[CI_RD_VIOL];
    assign cnt_wr_viol_o = cnt[CI_WR_VIOL];
endmodule

// File: rtl/xlat_frontend_chk.sv
module xlat_frontend_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid_i,
    input logic [63:0]      req_vaddr_i,
    input logic             req_phys_i,
    input logic             resp_valid_o,
    input logic [63:0]      resp_paddr_o,
    input logic [2:0]       resp_fault_o,
    input logic [2:0]       resp_status_o,
    input logic [CNT_W-1:0] cnt_rd_acc_o,
    input logic [CNT_W-1:0] cnt_wr_acc_o,
    input logic [CNT_W-1:0] cnt_rd_hit_o
);
    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_i |=> resp_valid_o);

    // R11
    idle_resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid_i |=> (!resp_valid_o && resp_fault_o == 3'd0 && resp_paddr_o == 64'd0));

    // R2
    phys_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_phys_i) |=> (resp_paddr_o == $past(req_vaddr_i)));

    // R2
    phys_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_phys_i) |=> ($stable(cnt_rd_acc_o) && $stable(cnt_wr_acc_o)));

    // R8
    mchk_has_high_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_o && resp_fault_o == 3'd4) |-> (resp_paddr_o[63:40] != 24'd0));

    // R5
    bad_addr_is_data_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_o && resp_status_o[2]) |-> (resp_fault_o == 3'd2 && resp_status_o[1]));

    // R9
    hit_implies_access_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd_hit_o != $past(cnt_rd_hit_o)) |-> (cnt_rd_acc_o != $past(cnt_rd_acc_o)));

    // R9
    hit_step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd_hit_o - $past(cnt_rd_hit_o)) <= CNT_W'(1));
endmodule

bind xlat_frontend xlat_frontend_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid_i   (req_valid_i),
    .req_vaddr_i   (req_vaddr_i),
    .req_phys_i    (req_phys_i),
    .resp_valid_o  (resp_valid_o),
    .resp_paddr_o  (resp_paddr_o),
    .resp_fault_o  (resp_fault_o),
    .resp_status_o (resp_status_o),
    .cnt_rd_acc_o  (cnt_rd_acc_o),
    .cnt_wr_acc_o  (cnt_wr_acc_o),
    .cnt_rd_hit_o  (cnt_rd_hit_o)
);

// File: tb/xlat_frontend_bench.sv
module xlat_frontend_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 0, req_phys_i = 0, req_write_i = 0, req_fetch_i = 0, req_kernel_i = 0;
    logic [63:0] req_vaddr_i = '0;
    logic [7:0]  ctx_asn_i = '0;
    logic [1:0]  ctl_spage_i = '0;
    logic        fill_en_i = 0;
    logic [29:0] fill_vpn_i = '0;
    logic [7:0]  fill_asn_i = '0;
    logic [27:0] fill_pfn_i = '0;
    logic        resp_valid_o;
    logic [63:0] resp_paddr_o;
    logic [2:0]  resp_fault_o, resp_status_o;
    logic [15:0] cnt_rd_acc_o, cnt_wr_acc_o, cnt_rd_hit_o, cnt_wr_hit_o, cnt_rd_viol_o, cnt_wr_viol_o;

    xlat_frontend u_xlat_frontend (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model of table and counters
    bit          m_val [16];
    logic [29:0] m_vpn [16];
    logic [7:0]  m_asn [16];
    logic [27:0] m_pfn [16];
    int          m_rr = 0;
    int          e_cnt [6];

    task automatic check(input string tag, input bit ok, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    function automatic logic [63:0] mk_va(input logic [29:0] vpn, input logic [12:0] off);
        return {{21{vpn[29]}}, vpn, off};
    endfunction

    task automatic do_req(input bit v, input logic [63:0] va, input bit ph, input bit wr,
                          input bit fe, input bit kn, input logic [7:0] asn, input logic [1:0] sp,
                          input bit fen, input logic [29:0] fvpn, input logic [7:0] fasn,
                          input logic [27:0] fpfn);
        logic [63:0] e_pa = '0;
        logic [2:0]  e_f = 3'd0, e_st = 3'd0;
        string       tag = "R11";
        bit          st = wr && !fe;
        if (v) begin
            if (ph) begin
                e_pa = va; tag = "R2";
            end else if (sp[1] && va[42:41] == 2'b10) begin
                if (!kn) begin e_f = fe ? 3'd1 : 3'd3; tag = "R4"; end
                else begin e_pa = va & 64'h0000_00FF_FFFF_FFFF; tag = "R3"; end
            end else begin
                e_cnt[st ? 1 : 0]++;
                if (!((&va[63:42]) || !(|va[63:42]))) begin
                    e_f = fe ? 3'd1 : 3'd2;
                    e_st = fe ? 3'd0 : {2'b11, st};
                    e_cnt[st ? 5 : 4]++;
                    tag = "R5";
                end else begin
                    int hi = -1;
                    for (int i = 15; i >= 0; i--)
                        if (m_val[i] && m_vpn[i] == va[42:13] && m_asn[i] == asn) hi = i;
                    if (hi < 0) begin
                        e_f = fe ? 3'd1 : 3'd2;
                        e_st = fe ? 3'd0 : {2'b00, st};
                        tag = "R7";
                    end else begin
                        e_pa = {23'd0, m_pfn[hi], va[12:0]};
                        e_cnt[st ? 3 : 2]++;
                        tag = "R6";
                    end
                end
            end
            if (e_f == 3'd0 && e_pa[63:40] != 0) begin e_f = 3'd4; tag = "R8"; end
        end
        req_valid_i = v; req_vaddr_i = va; req_phys_i = ph; req_write_i = wr;
        req_fetch_i = fe; req_kernel_i = kn; ctx_asn_i = asn; ctl_spage_i = sp;
        fill_en_i = fen; fill_vpn_i = fvpn; fill_asn_i = fasn; fill_pfn_i = fpfn;
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 0; fill_en_i = 0;
        check(tag, resp_valid_o == v && resp_paddr_o == e_pa && resp_fault_o == e_f &&
                   resp_status_o == e_st,
              $sformatf("got v=%0b pa=%h f=%0d st=%b exp v=%0b pa=%h f=%0d st=%b",
                        resp_valid_o, resp_paddr_o, resp_fault_o, resp_status_o,
                        v, e_pa, e_f, e_st));
        // R9 counters
        check("R9", cnt_rd_acc_o == 16'(e_cnt[0]) && cnt_wr_acc_o == 16'(e_cnt[1]) &&
                    cnt_rd_hit_o == 16'(e_cnt[2]) && cnt_wr_hit_o == 16'(e_cnt[3]) &&
                    cnt_rd_viol_o == 16'(e_cnt[4]) && cnt_wr_viol_o == 16'(e_cnt[5]),
              $sformatf("got cnt %0d %0d %0d %0d %0d %0d exp %0d %0d %0d %0d %0d %0d",
                        cnt_rd_acc_o, cnt_wr_acc_o, cnt_rd_hit_o, cnt_wr_hit_o,
                        cnt_rd_viol_o, cnt_wr_viol_o,
                        e_cnt[0], e_cnt[1], e_cnt[2], e_cnt[3], e_cnt[4], e_cnt[5]));
        if (fen) begin
            m_val[m_rr] = 1; m_vpn[m_rr] = fvpn; m_asn[m_rr] = fasn; m_pfn[m_rr] = fpfn;
            m_rr = (m_rr + 1) % 16;
        end
    endtask

    // simple lookup with no fill
    task automatic look(input logic [63:0] va, input bit ph, input bit wr, input bit fe,
                        input bit kn, input logic [7:0] asn, input logic [1:0] sp);
        do_req(1, va, ph, wr, fe, kn, asn, sp, 0, '0, '0, '0);
    endtask

    task automatic fill(input logic [29:0] vpn, input logic [7:0] asn, input logic [27:0] pfn);
        do_req(0, '0, 0, 0, 0, 0, '0, '0, 1, vpn, asn, pfn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_val[i] = 0;
        for (int i = 0; i < 6; i++) e_cnt[i] = 0;
        void'($urandom(32'd20240217));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1", resp_valid_o == 0 && cnt_rd_acc_o == 0 && cnt_wr_hit_o == 0 &&
                    cnt_wr_viol_o == 0,
              $sformatf("got v=%0b rdacc=%0d exp 0 0", resp_valid_o, cnt_rd_acc_o));
        // R1 empty table: lookup misses
        look(mk_va(30'h5, 13'h10), 0, 0, 0, 1, 8'd0, 2'b00);
        // R2 physical passthrough, R8 machine check on physical route
        look(64'h0000_0012_3456_7000, 1, 1, 0, 0, 8'd3, 2'b10);
        look(64'h0004_0000_0000_0040, 1, 0, 0, 1, 8'd0, 2'b00);
        // R3 kernel window
        look(64'hFFFF_FD12_3456_789A, 0, 0, 0, 1, 8'd0, 2'b10);
        look(64'h0000_0400_0000_1000, 0, 1, 0, 1, 8'd0, 2'b11);
        // window disabled: goes to lookup route
        look(64'hFFFF_FD12_3456_789A, 0, 0, 0, 1, 8'd0, 2'b01);
        // R4 non-kernel window data and fetch
        look(64'hFFFF_FD00_0000_0000, 0, 1, 0, 0, 8'd0, 2'b10);
        look(64'hFFFF_FD00_0000_0000, 0, 0, 1, 0, 8'd0, 2'b10);
        // R5 malformed addresses: store, load, fetch
        look(64'h0001_0000_0000_0000, 0, 1, 0, 1, 8'd0, 2'b00);
        look(64'h8000_0000_0000_0000, 0, 0, 0, 1, 8'd0, 2'b00);
        look(64'h0000_0400_0000_0000, 0, 0, 1, 1, 8'd0, 2'b00);
        // R10 same-cycle fill and lookup: old contents, then hit (R6)
        do_req(1, mk_va(30'h1234, 13'h55), 0, 0, 0, 1, 8'd7, 2'b00, 1, 30'h1234, 8'd7, 28'h0ABCDE);
        look(mk_va(30'h1234, 13'h55), 0, 0, 0, 1, 8'd7, 2'b00);
        look(mk_va(30'h1234, 13'h1FFF), 0, 1, 0, 0, 8'd7, 2'b00);
        // R7 space number mismatch, store miss
        look(mk_va(30'h1234, 13'h55), 0, 1, 0, 1, 8'd8, 2'b00);
        // R8 hit with frame bit 27 set
        fill(30'h3FFF_FFF0, 8'd1, 28'h8000_001);
        look(mk_va(30'h3FFF_FFF0, 13'h3), 0, 0, 0, 1, 8'd1, 2'b00);
        // R10 wrap: 16 more fills push out the first two slots
        for (int i = 0; i < 16; i++) fill(30'(32'h100 + i), 8'd2, 28'(i + 1));
        look(mk_va(30'h1234, 13'h0), 0, 0, 0, 1, 8'd7, 2'b00);
        look(mk_va(30'h100, 13'h0), 0, 0, 0, 1, 8'd2, 2'b00);
        look(mk_va(30'h10F, 13'h8), 0, 1, 0, 1, 8'd2, 2'b00);
        // R11 idle cycle
        do_req(0, 64'hDEAD, 0, 0, 0, 0, '0, '0, 0, '0, '0, '0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [63:0] va;
            logic [29:0] fv;
            int cat = $urandom % 8;
            fv = 30'($urandom % 24);
            if ($urandom % 2) fv = fv | 30'h2000_0000;
            case (cat)
                0: va = {($urandom % 4 == 0) ? 8'h01 : 8'h00, 56'($urandom)} & 64'h01FF_FFFF_FFFF;
                1: va = {21'h1FFFFF, 2'b10, 41'({$urandom, $urandom})};
                2: va = {32'($urandom), 32'($urandom)};
                default: va = mk_va(fv, 13'($urandom));
            endcase
            do_req($urandom % 8 != 0, va, cat == 0, 1'($urandom), ($urandom % 4) == 0,
                   1'($urandom), 8'($urandom % 3), 2'($urandom),
                   ($urandom % 4) == 0, 30'($urandom % 24) | (($urandom % 2) ? 30'h2000_0000 : 30'h0),
                   8'($urandom % 3), 28'($urandom) & (($urandom % 8 == 0) ? 28'hFFF_FFFF : 28'h7FF_FFFF));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule